// File: doc/BRIEF.md
# Aging-Counter Page Victim Selector

This block picks a page frame to evict when a page fault needs a free slot. It keeps a short usage history for each of `NUM_FRAMES` frames, which together approximate least-recently-used order. Each frame holds a `CNT_W`-bit history counter and a one-bit "touched" flag. Memory accesses set the touched flag of the frame they hit. A periodic tick pulse folds every frame's flag into its history and then clears all the flags.

When a fault request arrives, the block returns the frame with the lowest history value one cycle later. A low value means the frame was used least, or least recently. When the operating logic brings a new page into a frame, it issues a load command. The load wipes that frame's history and marks the frame as touched, so the new page is not chosen again straight away.

Top module: `aging_victim_sel`

## Requirements
- R1: After reset every history counter and touched flag is zero and `victim_valid_o` is 0. A fault request made immediately after reset therefore returns frame 0.
- R2: An access (`acc_valid_i`=1) sets the touched flag of frame `acc_frame_i`. No other frame's flag changes.
- R3: On a tick, each frame's counter becomes {flag, counter[CNT_W-1:1]}. That is a logical right shift by one, with the touched flag entering bit CNT_W-1 (the MSB).
- R4: A tick clears every touched flag in the same cycle as the shift.
- R5: The victim is the frame whose counter holds the smallest unsigned value.
- R6: When two or more frames share the smallest value, the victim is the one with the lowest index.
- R7: A load (`load_valid_i`=1) sets the counter of frame `load_frame_i` to 0 and its touched flag to 1.
- R8: An access in the same cycle as a tick is not shifted in by that tick. It sets the flag afterwards, so it counts toward the following tick period.
- R9: `victim_valid_o` is 1 exactly in the cycle after each cycle with `fault_req_i`=1. `victim_frame_o` is then the choice made from the counters as they stood in the request cycle.
- R10: A load and a tick in the same cycle on the same frame: the load wins, leaving the counter at 0 and the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access to a frame this cycle |
| acc_frame_i | input | IDX_W | Frame index of the access |
| tick_i | input | 1 | Aging tick pulse |
| load_valid_i | input | 1 | New page installed this cycle |
| load_frame_i | input | IDX_W | Frame index of the install |
| fault_req_i | input | 1 | Request a victim |
| victim_valid_o | output | 1 | Victim result valid |
| victim_frame_o | output | IDX_W | Chosen victim frame |

## Verification
Two functions can fall in the same cycle: an access and a tick. The bench provokes this by driving an access to a frame with a zero history in the same cycle as a tick. It then requests a victim right away and expects that frame to still be chosen, because its history is still zero. After one more tick, that frame must no longer be the victim, which shows the deferred flag was shifted in then. A load issued on the same cycle as a tick is handled the same way: the frame must first win as victim, and then lose after the following tick.

// File: rtl/aging_pkg.sv
package aging_pkg;
  localparam int unsigned DEF_FRAMES = 4;
  localparam int unsigned DEF_CNT_W  = 8;
endpackage

// File: rtl/aging_frame.sv
module aging_frame #(
  parameter int unsigned CNT_W = aging_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_hit_i,
  input  logic             tick_i,
  input  logic             load_hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ref_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else if (load_hit_i) begin
      cnt_q <= '0;
      ref_q <= 1'b1;
    end else begin
      if (tick_i) cnt_q <= {ref_q, cnt_q[CNT_W-1:1]};
      // same-cycle access lands after the clear
      ref_q <= tick_i ? acc_hit_i : (ref_q | acc_hit_i);
    end
  end

  assign cnt_o = cnt_q;
  assign ref_o = ref_q;
endmodule

// File: rtl/aging_min_tree.sv
module aging_min_tree #(
  parameter int unsigned N     = aging_pkg::DEF_FRAMES,
  parameter int unsigned W     = aging_pkg::DEF_CNT_W,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] val_i,
  output logic [IDX_W-1:0]    idx_o
);
  localparam int unsigned LEAVES = 1 << IDX_W;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic [W-1:0]     node_val [NODES];
  logic [IDX_W-1:0] node_idx [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign node_val[LEAVES-1+i] = val_i[i];
    end else begin : g_pad
      assign node_val[LEAVES-1+i] = '1;
    end
    assign node_idx[LEAVES-1+i] = IDX_W'(i);
  end

  // left subtree holds lower indices; <= keeps it on a tie
  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic pick_left;
    assign pick_left   = node_val[2*k+1] <= node_val[2*k+2];
    assign node_val[k] = pick_left ? node_val[2*k+1] : node_val[2*k+2];
    assign node_idx[k] = pick_left ? node_idx[2*k+1] : node_idx[2*k+2];
  end

  assign idx_o = node_idx[0];
endmodule

// File: rtl/aging_victim_sel.sv
module aging_victim_sel #(
  parameter int unsigned NUM_FRAMES = aging_pkg::DEF_FRAMES,
  parameter int unsigned CNT_W      = aging_pkg::DEF_CNT_W,
  localparam int unsigned IDX_W     = $clog2(NUM_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic [IDX_W-1:0] acc_frame_i,
  input  logic             tick_i,
  input  logic             load_valid_i,
  input  logic [IDX_W-1:0] load_frame_i,
  input  logic             fault_req_i,
  output logic             victim_valid_o,
  output logic [IDX_W-1:0] victim_frame_o
);
  logic [NUM_FRAMES-1:0][CNT_W-1:0] cnt_vec;
  logic [NUM_FRAMES-1:0]            ref_vec;
  logic [IDX_W-1:0]                 min_idx;

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
    aging_frame #(.CNT_W(CNT_W)) i_frame (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .acc_hit_i  (acc_valid_i && (acc_frame_i == IDX_W'(i))),
      .tick_i     (tick_i),
      .load_hit_i (load_valid_i && (load_frame_i == IDX_W'(i))),
      .cnt_o      (cnt_vec[i]),
      .ref_o      (ref_vec[i])
    );
  end

  aging_min_tree #(.N(NUM_FRAMES), .W(CNT_W), .IDX_W(IDX_W)) i_min (
    .val_i (cnt_vec),
    .idx_o (min_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_valid_o <= 1'b0;
      victim_frame_o <= '0;
    end else begin
      victim_valid_o <= fault_req_i;
      if (fault_req_i) victim_frame_o <= min_idx;
    end
  end
endmodule

// File: rtl/aging_victim_sel_chk.sv
module aging_victim_sel_chk #(
  parameter int unsigned NUM_FRAMES = aging_pkg::DEF_FRAMES,
  parameter int unsigned CNT_W      = aging_pkg::DEF_CNT_W,
  parameter int unsigned IDX_W      = $clog2(NUM_FRAMES)
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             acc_valid_i,
  input logic                             tick_i,
  input logic                             load_valid_i,
  input logic [IDX_W-1:0]                 load_frame_i,
  input logic                             fault_req_i,
  input logic                             victim_valid_o,
  input logic [IDX_W-1:0]                 victim_frame_o,
  input logic [NUM_FRAMES-1:0][CNT_W-1:0] cnt_vec,
  input logic [NUM_FRAMES-1:0]            ref_vec
);
  logic [NUM_FRAMES-1:0][CNT_W-1:0] snap_q;
  logic                             snap_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else if (fault_req_i) snap_q <= cnt_vec;
  end

  always_comb begin
    snap_ok = 1'b1;
    for (int i = 0; i < NUM_FRAMES; i++) begin
      if (IDX_W'(i) < victim_frame_o && snap_q[i] <= snap_q[victim_frame_o]) snap_ok = 1'b0;
      if (IDX_W'(i) > victim_frame_o && snap_q[i] <  snap_q[victim_frame_o]) snap_ok = 1'b0;
    end
  end

  p_valid_follows_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_req_i |=> victim_valid_o);
  p_valid_only_after_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_req_i |=> !victim_valid_o);
  p_victim_is_min_r5_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> snap_ok);
  p_load_resets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_i |=> (cnt_vec[$past(load_frame_i)] == '0) && ref_vec[$past(load_frame_i)]);
  p_tick_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(load_valid_i && load_frame_i == '0)) |=>
      cnt_vec[0] == {$past(ref_vec[0]), $past(cnt_vec[0][CNT_W-1:1])});
  p_tick_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_valid_i && !acc_valid_i) |=> ref_vec == '0);
endmodule

bind aging_victim_sel aging_victim_sel_chk #(
  .NUM_FRAMES(NUM_FRAMES), .CNT_W(CNT_W), .IDX_W(IDX_W)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .acc_valid_i    (acc_valid_i),
  .tick_i         (tick_i),
  .load_valid_i   (load_valid_i),
  .load_frame_i   (load_frame_i),
  .fault_req_i    (fault_req_i),
  .victim_valid_o (victim_valid_o),
  .victim_frame_o (victim_frame_o),
  .cnt_vec        (cnt_vec),
  .ref_vec        (ref_vec)
);

// File: tb/test_aging_victim_sel.sv
module test_aging_victim_sel;
  localparam int unsigned NF = 4;
  localparam int unsigned IW = 2;

  typedef struct packed {
    logic          acc;
    logic [IW-1:0] af;
    logic          tick;
    logic          load;
    logic [IW-1:0] lf;
    logic          fault;
    logic [IW-1:0] ef;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0}, // 0  R1 R6 all zero
    '{1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0}, // 1  R2
    '{1'b1, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0}, // 2  R2
    '{1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0}, // 3  R3 -> 00 00 80 80
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0}, // 4  R6 tie 0/1
    '{1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0}, // 5
    '{1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0}, // 6  -> 80 00 40 40
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd1}, // 7  R5
    '{1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0}, // 8  R8 access+tick -> 40 00 20 20
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd1}, // 9  R8 frame1 still 00
    '{1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0}, // 10 -> 20 80 10 10
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd2}, // 11 R6 tie 2/3
    '{1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 1'b0, 2'd0}, // 12 R7 load f2
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd2}, // 13 R7
    '{1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0}, // 14 -> 10 40 80 08
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd3}, // 15 R3 R7 flag from load
    '{1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0}, // 16 -> 08 20 40 04
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd3}, // 17 R5
    '{1'b1, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0}, // 18 R2
    '{1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0}, // 19 -> 04 10 20 82
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0}, // 20 R5 R3
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0}  // 21 R9 back-to-back
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          acc_valid_i = 1'b0;
  logic [IW-1:0] acc_frame_i = '0;
  logic          tick_i = 1'b0;
  logic          load_valid_i = 1'b0;
  logic [IW-1:0] load_frame_i = '0;
  logic          fault_req_i = 1'b0;
  logic          victim_valid_o;
  logic [IW-1:0] victim_frame_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk_i = ~clk_i;

  aging_victim_sel #(.NUM_FRAMES(NF), .CNT_W(8)) i_aging_victim_sel (
    .clk_i, .rst_ni, .acc_valid_i, .acc_frame_i, .tick_i,
    .load_valid_i, .load_frame_i, .fault_req_i, .victim_valid_o, .victim_frame_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic acc, input logic [IW-1:0] af, input logic tick,
                      input logic load, input logic [IW-1:0] lf, input logic fault);
    acc_valid_i = acc; acc_frame_i = af; tick_i = tick;
    load_valid_i = load; load_frame_i = lf; fault_req_i = fault;
    @(posedge clk_i);
    #1;
    acc_valid_i = 1'b0; tick_i = 1'b0; load_valid_i = 1'b0; fault_req_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic expect_victim(input string req, input int exp);
    step(1'b0, '0, 1'b0, 1'b0, '0, 1'b1);
    check({req, " valid"}, int'(victim_valid_o), 1);
    check({req, " frame"}, int'(victim_frame_o), exp);
  endtask

  initial begin
    do_reset();
    check("R1 valid after reset", int'(victim_valid_o), 0);
    check("R1 frame after reset", int'(victim_frame_o), 0);

    for (int v = 0; v < NV; v++) begin
      step(VECS[v].acc, VECS[v].af, VECS[v].tick, VECS[v].load, VECS[v].lf, VECS[v].fault);
      if (VECS[v].fault) begin
        check($sformatf("R9 vec %0d valid", v), int'(victim_valid_o), 1);
        check($sformatf("R5 vec %0d frame", v), int'(victim_frame_o), int'(VECS[v].ef));
      end else begin
        check($sformatf("R9 vec %0d idle", v), int'(victim_valid_o), 0);
      end
    end

    // R4: flags cleared by tick, so frame 0 ages to 40 below the others at 80
    do_reset();
    step(1'b1, 2'd0, 1'b0, 1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0, '0, 1'b0);
    step(1'b1, 2'd1, 1'b0, 1'b0, '0, 1'b0);
    step(1'b1, 2'd2, 1'b0, 1'b0, '0, 1'b0);
    step(1'b1, 2'd3, 1'b0, 1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0, '0, 1'b0);
    expect_victim("R4", 0);

    // R10: load on tick cycle wins; its flag ages frame 0 on the next tick
    do_reset();
    step(1'b1, 2'd1, 1'b0, 1'b0, '0, 1'b0);
    step(1'b1, 2'd2, 1'b0, 1'b0, '0, 1'b0);
    step(1'b1, 2'd3, 1'b0, 1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b1, 1'b1, 2'd0, 1'b0);
    expect_victim("R10 after load+tick", 0);
    step(1'b0, '0, 1'b1, 1'b0, '0, 1'b0);
    expect_victim("R10 R7 flag aged in", 1);

    // R8: access on tick of zero frame; still victim, then aged out
    do_reset();
    step(1'b1, 2'd1, 1'b0, 1'b0, '0, 1'b0);
    step(1'b1, 2'd2, 1'b0, 1'b0, '0, 1'b0);
    step(1'b1, 2'd3, 1'b0, 1'b0, '0, 1'b0);
    step(1'b1, 2'd0, 1'b1, 1'b0, '0, 1'b0);
    expect_victim("R8 deferred", 0);
    step(1'b0, '0, 1'b1, 1'b0, '0, 1'b0);
    expect_victim("R8 next period", 1);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule